// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor that completes one instruction in every clock cycle. On each rising edge it takes the word that the program counter points to in a small on-chip instruction store and decodes it. It reads two source registers and forms a result in the arithmetic unit. If needed it reads or writes a word of on-chip data memory. It then writes the destination register and moves the program counter to the next address. The instruction set covers register-register arithmetic and logic, add-immediate, load-upper-immediate, word load and store, five conditional branches, plain jump, jump-and-link and jump-through-register.

A test port stands beside the core. While reset is held, it fills the instruction store one word at a time. At any time, it reads out any register and any data-memory word without disturbing execution. The reset input is asynchronous and active low. Inside the block its release is retimed through two flops, so the first instruction executes on the third rising edge after `rst_ni` goes high. The program counter is visible on `pc_o`, so a program can end in a jump-to-self loop that the environment detects.

Top module: `scpu_core`

## Requirements
- R1: While reset is active, the program counter reads 0. Register 29 reads 128 and every other register reads 0. This holds again after any later reset, whatever the registers held before.
- R2: Register 0 always reads 0. An instruction that names it as destination leaves it at 0.
- R3: Register-register instructions use opcode 000000 and select on bits [5:0]. 100000 adds, 100010 subtracts, 100100 is AND, 100101 is OR and 101010 is signed set-less-than. Each writes the field at bits [15:11].
- R4: Add-immediate (opcode 001000) adds the sign-extended bits [15:0] to the register at bits [25:21]. Load-upper (opcode 001111) writes bits [15:0] shifted left by 16. Both write the register at bits [20:16].
- R5: Word store (opcode 101101) writes the register at [20:16] into data memory at base plus sign-extended offset. Word load (opcode 101100) reads that location into the register at [20:16]. Only byte-address bits [6:2] select among the 32 words. A load in the cycle after a store sees the stored value.
- R6: Equal-branch (opcode 001010) and not-equal-branch (opcode 001011) compare the registers at [25:21] and [20:16]. When taken, the next PC is PC+4 plus the sign-extended offset times four, including negative offsets. Otherwise the next PC is PC+4.
- R7: Three branches use the same target rule on the register at [25:21]. Opcode 001110 branches when it is signed-less-than the register at [20:16]. Opcode 001100 branches when it is nonzero. Opcode 001101 branches when it is signed non-negative; its [20:16] field holds 00001 and does not name a register.
- R8: Jump (opcode 000010) sets the PC to {PC[31:28], bits[25:0], 00}. Jump-and-link (opcode 000011) does the same and also writes PC+4 into register 31.
- R9: An opcode-000000 word with function 001000 loads the PC from the register at [25:21] and writes no register.
- R10: A test-port write lands in the instruction store only while reset is active. The store holds 64 words and is fetched with PC[7:2]. A write attempted while running changes nothing that executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tp_imem_we_i | input | 1 | Instruction-store write strobe (honoured only in reset) |
| tp_imem_addr_i | input | 6 | Instruction-store word index |
| tp_imem_data_i | input | 32 | Instruction word to store |
| tp_reg_sel_i | input | 5 | Register to observe |
| tp_reg_data_o | output | 32 | Value of the observed register |
| tp_dmem_sel_i | input | 5 | Data-memory word to observe |
| tp_dmem_data_o | output | 32 | Value of the observed data word |
| pc_o | output | 32 | Current program counter |

## Verification
Jump-and-link is the case where a control transfer and a register write happen on the same edge. The same edge loads the PC with the target and register 31 with the return address. The return path that follows then reads that link in a jump-through-register. The test program calls a routine that copies register 31 and returns through it. The copied value and the instruction after the call must both reach the registers, and the instruction after the return must not. A store followed at once by a load of the same word is the second coincidence. It is judged by the loaded register matching the data word seen on the test port. Every program is rerun over all ordered pairs of eight edge-case operands: zero, ±1, the two signed extremes, and mixed-sign values. Expected values for arithmetic and branches are computed from the operands.

// File: rtl/scpu_pkg.sv
package scpu_pkg;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_ADDI  = 6'b001000;
  localparam logic [5:0] OPC_LUI   = 6'b001111;
  localparam logic [5:0] OPC_LW    = 6'b101100;
  localparam logic [5:0] OPC_SW    = 6'b101101;
  localparam logic [5:0] OPC_BEQ   = 6'b001010;
  localparam logic [5:0] OPC_BNE   = 6'b001011;
  localparam logic [5:0] OPC_BLT   = 6'b001110;
  localparam logic [5:0] OPC_BNEZ  = 6'b001100;
  localparam logic [5:0] OPC_BGEZ  = 6'b001101;
  localparam logic [5:0] OPC_J     = 6'b000010;
  localparam logic [5:0] OPC_JAL   = 6'b000011;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;
  localparam logic [5:0] FN_JR  = 6'b001000;

  // 3-bit operation class handed from decoder to ALU control
  localparam logic [2:0] AOP_MEM   = 3'b000;
  localparam logic [2:0] AOP_EQ    = 3'b001;
  localparam logic [2:0] AOP_RTYPE = 3'b010;
  localparam logic [2:0] AOP_LT    = 3'b011;
  localparam logic [2:0] AOP_ADDI  = 3'b100;
  localparam logic [2:0] AOP_LUI   = 3'b101;
  localparam logic [2:0] AOP_NE    = 3'b110;
  localparam logic [2:0] AOP_PASS  = 3'b111;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_LUI, ALU_PASSA
  } alu_fn_e;

  typedef enum logic [2:0] {
    BR_NONE, BR_EQ, BR_NE, BR_LT, BR_NZ, BR_GEZ
  } br_kind_e;

  typedef struct packed {
    logic       reg_write;
    logic       reg_dst;
    logic       alu_src;
    logic       mem_read;
    logic       mem_write;
    logic       mem_to_reg;
    logic       branch;
    logic       jump;
    logic       link;
    logic       jr;
    logic [2:0] alu_op;
    br_kind_e   br_kind;
  } ctrl_t;

endpackage

// File: rtl/scpu_decode.sv
module scpu_decode
  import scpu_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.br_kind = BR_NONE;
    unique case (opcode_i)
      OPC_RTYPE: begin
        ctrl_o.alu_op = AOP_RTYPE;
        if (funct_i == FN_JR) begin
          ctrl_o.jr = 1'b1;
        end else begin
          ctrl_o.reg_write = 1'b1;
          ctrl_o.reg_dst   = 1'b1;
        end
      end
      OPC_ADDI: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.alu_op    = AOP_ADDI;
      end
      OPC_LUI: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.alu_op    = AOP_LUI;
      end
      OPC_LW: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.mem_read   = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.alu_op     = AOP_MEM;
      end
      OPC_SW: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
        ctrl_o.alu_op    = AOP_MEM;
      end
      OPC_BEQ: begin
        ctrl_o.branch  = 1'b1;
        ctrl_o.alu_op  = AOP_EQ;
        ctrl_o.br_kind = BR_EQ;
      end
      OPC_BNE: begin
        ctrl_o.branch  = 1'b1;
        ctrl_o.alu_op  = AOP_NE;
        ctrl_o.br_kind = BR_NE;
      end
      OPC_BLT: begin
        ctrl_o.branch  = 1'b1;
        ctrl_o.alu_op  = AOP_LT;
        ctrl_o.br_kind = BR_LT;
      end
      OPC_BNEZ: begin
        ctrl_o.branch  = 1'b1;
        ctrl_o.alu_op  = AOP_PASS;
        ctrl_o.br_kind = BR_NZ;
      end
      OPC_BGEZ: begin
        ctrl_o.branch  = 1'b1;
        ctrl_o.alu_op  = AOP_PASS;
        ctrl_o.br_kind = BR_GEZ;
      end
      OPC_J: begin
        ctrl_o.jump = 1'b1;
      end
      OPC_JAL: begin
        ctrl_o.jump      = 1'b1;
        ctrl_o.link      = 1'b1;
        ctrl_o.reg_write = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
  import scpu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2:0]    alu_op_i,
  input  logic [5:0]    funct_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] result_o,
  output logic          zero_o
);

  alu_fn_e fn;

  // operation class plus function field -> concrete operation
  always_comb begin
    unique case (alu_op_i)
      AOP_MEM, AOP_ADDI: fn = ALU_ADD;
      AOP_EQ, AOP_NE:    fn = ALU_SUB;
      AOP_LT:            fn = ALU_SLT;
      AOP_LUI:           fn = ALU_LUI;
      AOP_PASS:          fn = ALU_PASSA;
      AOP_RTYPE: begin
        unique case (funct_i)
          FN_SUB:  fn = ALU_SUB;
          FN_AND:  fn = ALU_AND;
          FN_OR:   fn = ALU_OR;
          FN_SLT:  fn = ALU_SLT;
          default: fn = ALU_ADD;
        endcase
      end
      default: fn = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (fn)
      ALU_SUB:   result_o = a_i - b_i;
      ALU_AND:   result_o = a_i & b_i;
      ALU_OR:    result_o = a_i | b_i;
      ALU_SLT:   result_o = {{(DW-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      ALU_LUI:   result_o = b_i << 16;
      ALU_PASSA: result_o = a_i;
      default:   result_o = a_i + b_i;
    endcase
  end

  assign zero_o = (result_o == '0);

endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile #(
  parameter int          DW      = 32,
  parameter int          NREGS   = 32,
  parameter int          SP_IDX  = 29,
  parameter logic [31:0] SP_INIT = 32'd128,
  localparam int         AW      = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  input  logic [AW-1:0] rt_sel_i,
  output logic [DW-1:0] ra_data_o,
  output logic [DW-1:0] rb_data_o,
  output logic [DW-1:0] rt_data_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i
);

  logic [DW-1:0] regs_q [NREGS];
  logic          wr_en;

  assign wr_en = we_i && (wa_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) begin
        regs_q[i] <= (i == SP_IDX) ? SP_INIT[DW-1:0] : '0;
      end
    end else if (wr_en) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign ra_data_o = (ra_i == '0)     ? '0 : regs_q[ra_i];
  assign rb_data_o = (rb_i == '0)     ? '0 : regs_q[rb_i];
  assign rt_data_o = (rt_sel_i == '0) ? '0 : regs_q[rt_sel_i];

endmodule

// File: rtl/scpu_dmem.sv
module scpu_dmem #(
  parameter int  DW    = 32,
  parameter int  DEPTH = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [AW-1:0] tp_addr_i,
  output logic [DW-1:0] tp_rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o    = mem_q[addr_i];
  assign tp_rdata_o = mem_q[tp_addr_i];

endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scpu_pkg::*;
#(
  parameter int          IMEM_DEPTH = 64,
  parameter int          DMEM_DEPTH = 32,
  parameter int          NREGS      = 32,
  parameter int          SP_IDX     = 29,
  parameter int          LINK_IDX   = 31,
  parameter logic [31:0] SP_INIT    = 32'd128,
  localparam int         DW         = 32,
  localparam int         IAW        = $clog2(IMEM_DEPTH),
  localparam int         DAW        = $clog2(DMEM_DEPTH),
  localparam int         RAW        = $clog2(NREGS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tp_imem_we_i,
  input  logic [IAW-1:0] tp_imem_addr_i,
  input  logic [DW-1:0]  tp_imem_data_i,
  input  logic [RAW-1:0] tp_reg_sel_i,
  output logic [DW-1:0]  tp_reg_data_o,
  input  logic [DAW-1:0] tp_dmem_sel_i,
  output logic [DW-1:0]  tp_dmem_data_o,
  output logic [DW-1:0]  pc_o
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // instruction store
  logic [DW-1:0] imem_q [IMEM_DEPTH];
  logic          imem_we;
  logic [DW-1:0] instr;
  logic [DW-1:0] pc_q, pc_d;

  assign imem_we = tp_imem_we_i && !rst_n;

  always_ff @(posedge clk_i) begin
    if (imem_we) begin
      imem_q[tp_imem_addr_i] <= tp_imem_data_i;
    end
  end
  assign instr = imem_q[pc_q[IAW+1:2]];

  // fields
  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd;
  logic [15:0] imm;
  logic [25:0] jaddr;

  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign funct  = instr[5:0];
  assign imm    = instr[15:0];
  assign jaddr  = instr[25:0];

  ctrl_t ctrl;

  scpu_decode u_decode (
    .opcode_i (opcode),
    .funct_i  (funct),
    .ctrl_o   (ctrl)
  );

  // register file
  logic [DW-1:0]  rs_data, rt_data;
  logic           rf_we;
  logic [RAW-1:0] rf_waddr;
  logic [DW-1:0]  rf_wdata;

  scpu_regfile #(
    .DW      (DW),
    .NREGS   (NREGS),
    .SP_IDX  (SP_IDX),
    .SP_INIT (SP_INIT)
  ) u_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .ra_i      (rs[RAW-1:0]),
    .rb_i      (rt[RAW-1:0]),
    .rt_sel_i  (tp_reg_sel_i),
    .ra_data_o (rs_data),
    .rb_data_o (rt_data),
    .rt_data_o (tp_reg_data_o),
    .we_i      (rf_we),
    .wa_i      (rf_waddr),
    .wd_i      (rf_wdata)
  );

  // execute
  logic [DW-1:0] imm_sext, alu_b, alu_res;
  logic          alu_zero;

  assign imm_sext = {{(DW-16){imm[15]}}, imm};
  assign alu_b    = ctrl.alu_src ? imm_sext : rt_data;

  scpu_alu #(.DW(DW)) u_alu (
    .alu_op_i (ctrl.alu_op),
    .funct_i  (funct),
    .a_i      (rs_data),
    .b_i      (alu_b),
    .result_o (alu_res),
    .zero_o   (alu_zero)
  );

  // data memory
  logic          dmem_we, dmem_re;
  logic [DW-1:0] dmem_rdata;

  assign dmem_we = ctrl.mem_write && rst_n;
  assign dmem_re = ctrl.mem_read;

  scpu_dmem #(.DW(DW), .DEPTH(DMEM_DEPTH)) u_dmem (
    .clk_i      (clk_i),
    .we_i       (dmem_we),
    .addr_i     (alu_res[DAW+1:2]),
    .wdata_i    (rt_data),
    .rdata_o    (dmem_rdata),
    .tp_addr_i  (tp_dmem_sel_i),
    .tp_rdata_o (tp_dmem_data_o)
  );

  // write-back
  logic [DW-1:0] pc_plus4;
  logic          link, jump, jr;

  assign pc_plus4 = pc_q + 32'd4;
  assign link     = ctrl.link;
  assign jump     = ctrl.jump;
  assign jr       = ctrl.jr;
  assign rf_we    = ctrl.reg_write && rst_n;

  always_comb begin
    if (link)              rf_waddr = LINK_IDX[RAW-1:0];
    else if (ctrl.reg_dst) rf_waddr = rd[RAW-1:0];
    else                   rf_waddr = rt[RAW-1:0];
  end

  always_comb begin
    if (link)                 rf_wdata = pc_plus4;
    else if (ctrl.mem_to_reg) rf_wdata = dmem_rdata;
    else                      rf_wdata = alu_res;
  end

  // branch resolution
  logic br_cond, branch_taken;

  always_comb begin
    unique case (ctrl.br_kind)
      BR_EQ:   br_cond = alu_zero;
      BR_NE:   br_cond = !alu_zero;
      BR_LT:   br_cond = alu_res[0];
      BR_NZ:   br_cond = !alu_zero;
      BR_GEZ:  br_cond = !alu_res[DW-1];
      default: br_cond = 1'b0;
    endcase
  end
  assign branch_taken = ctrl.branch && br_cond;

  // next PC
  logic [DW-1:0] br_target, j_target;

  assign br_target = pc_plus4 + {imm_sext[DW-3:0], 2'b00};
  assign j_target  = {pc_q[31:28], jaddr, 2'b00};

  always_comb begin
    if (jr)                pc_d = rs_data;
    else if (jump)         pc_d = j_target;
    else if (branch_taken) pc_d = br_target;
    else                   pc_d = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/scpu_core_chk.sv
module scpu_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rst_n,
  input logic [31:0] pc_q,
  input logic [15:0] imm,
  input logic        branch_taken,
  input logic        jump,
  input logic        jr,
  input logic        link,
  input logic        rf_we,
  input logic [4:0]  rf_waddr,
  input logic [31:0] rf_wdata,
  input logic        dmem_we,
  input logic        dmem_re
);

  p_pc_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_n |=> (pc_q == 32'd0));

  p_seq_pc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_n && !branch_taken && !jump && !jr) |=> (pc_q == $past(pc_q) + 32'd4));

  p_branch_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_n && branch_taken) |=>
      (pc_q == $past(pc_q) + 32'd4 + {{14{$past(imm[15])}}, $past(imm), 2'b00}));

  p_link_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_n && link) |-> (rf_we && rf_waddr == 5'd31 && rf_wdata == pc_q + 32'd4));

  p_jr_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jr |-> !rf_we);

  p_store_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we |-> (!rf_we && !dmem_re));

endmodule

bind scpu_core scpu_core_chk u_chk (.*);

// File: tb/scpu_core_tb.sv
module scpu_core_tb;

  localparam logic [5:0] O_ADDI = 6'b001000, O_LUI = 6'b001111, O_LW = 6'b101100,
                         O_SW = 6'b101101, O_BEQ = 6'b001010, O_BNE = 6'b001011,
                         O_BLT = 6'b001110, O_BNEZ = 6'b001100, O_BGEZ = 6'b001101,
                         O_J = 6'b000010, O_JAL = 6'b000011;
  localparam int PROG_LEN = 34;
  localparam logic [31:0] HALT_PC = 32'd132;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tp_imem_we_i = 1'b0;
  logic [5:0]  tp_imem_addr_i = '0;
  logic [31:0] tp_imem_data_i = '0;
  logic [4:0]  tp_reg_sel_i = '0;
  logic [31:0] tp_reg_data_o;
  logic [4:0]  tp_dmem_sel_i = '0;
  logic [31:0] tp_dmem_data_o;
  logic [31:0] pc_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #4 clk_i = ~clk_i;

  scpu_core u_dut (.*);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b0, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int im);
    return {op, 5'(rs), 5'(rt), 16'(im)};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] op, input int a);
    return {op, 26'(a)};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd_reg(input int idx, output logic [31:0] v);
    tp_reg_sel_i = 5'(idx);
    #1 v = tp_reg_data_o;
  endtask

  task automatic rd_mem(input int idx, output logic [31:0] v);
    tp_dmem_sel_i = 5'(idx);
    #1 v = tp_dmem_data_o;
  endtask

  task automatic imem_write(input int addr, input logic [31:0] data);
    tp_imem_we_i   = 1'b1;
    tp_imem_addr_i = 6'(addr);
    tp_imem_data_i = data;
    @(negedge clk_i);
    tp_imem_we_i   = 1'b0;
  endtask

  task automatic run_pair(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] prog [PROG_LEN];
    logic [15:0] lo_a, lo_b, hi_a, hi_b;
    logic [31:0] v, t;
    bit halted;
    lo_a = a[15:0];
    lo_b = b[15:0];
    t = a - {{16{lo_a[15]}}, lo_a}; hi_a = t[31:16];
    t = b - {{16{lo_b[15]}}, lo_b}; hi_b = t[31:16];

    prog[0]  = enc_i(O_LUI, 0, 1, int'(hi_a));
    prog[1]  = enc_i(O_ADDI, 1, 1, int'(lo_a));
    prog[2]  = enc_i(O_LUI, 0, 2, int'(hi_b));
    prog[3]  = enc_i(O_ADDI, 2, 2, int'(lo_b));
    prog[4]  = enc_r(1, 2, 3, 6'b100000);
    prog[5]  = enc_r(1, 2, 4, 6'b100010);
    prog[6]  = enc_r(1, 2, 5, 6'b100100);
    prog[7]  = enc_r(1, 2, 6, 6'b100101);
    prog[8]  = enc_r(1, 2, 7, 6'b101010);
    prog[9]  = enc_i(O_SW, 29, 3, 4);     // 132 -> word 1 (bits [6:2])
    prog[10] = enc_i(O_SW, 0, 4, 12);     // word 3
    prog[11] = enc_i(O_LW, 0, 8, 12);
    prog[12] = enc_i(O_BEQ, 1, 2, 1);
    prog[13] = enc_i(O_ADDI, 0, 9, 1);
    prog[14] = enc_i(O_BNE, 1, 2, 1);
    prog[15] = enc_i(O_ADDI, 0, 10, 1);
    prog[16] = enc_i(O_BLT, 1, 2, 1);
    prog[17] = enc_i(O_ADDI, 0, 11, 1);
    prog[18] = enc_i(O_BNEZ, 1, 0, 1);
    prog[19] = enc_i(O_ADDI, 0, 12, 1);
    prog[20] = enc_i(O_BGEZ, 1, 1, 1);
    prog[21] = enc_i(O_ADDI, 0, 13, 1);
    prog[22] = enc_j(O_JAL, 25);
    prog[23] = enc_i(O_ADDI, 0, 14, 7);
    prog[24] = enc_j(O_J, 28);
    prog[25] = enc_i(O_ADDI, 31, 15, 0);
    prog[26] = enc_r(31, 0, 0, 6'b001000);
    prog[27] = enc_i(O_ADDI, 0, 16, 9);
    prog[28] = enc_i(O_ADDI, 0, 0, 5);
    prog[29] = enc_i(O_ADDI, 0, 18, 3);
    prog[30] = enc_i(O_ADDI, 19, 19, 1);
    prog[31] = enc_i(O_ADDI, 18, 18, -1);
    prog[32] = enc_i(O_BNE, 18, 0, -3);
    prog[33] = enc_j(O_J, 33);

    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R1", "pc in reset", pc_o, 32'd0);
    rd_reg(29, v); chk("R1", "sp in reset", v, 32'd128);
    rd_reg(3, v);  chk("R1", "r3 in reset", v, 32'd0);
    rd_reg(31, v); chk("R1", "r31 in reset", v, 32'd0);
    for (int i = 0; i < PROG_LEN; i++) imem_write(i, prog[i]);
    rst_ni = 1'b1;

    halted = 1'b0;
    for (int c = 0; c < 400 && !halted; c++) begin
      @(negedge clk_i);
      if (pc_o == HALT_PC) halted = 1'b1;
    end
    chk("R6", "halt reached", {31'b0, halted}, 32'd1);
    @(negedge clk_i);

    rd_reg(1, v);  chk("R4", "lui+addi a", v, a);
    rd_reg(2, v);  chk("R4", "lui+addi b", v, b);
    rd_reg(3, v);  chk("R3", "add", v, a + b);
    rd_reg(4, v);  chk("R3", "sub", v, a - b);
    rd_reg(5, v);  chk("R3", "and", v, a & b);
    rd_reg(6, v);  chk("R3", "or", v, a | b);
    rd_reg(7, v);  chk("R3", "slt", v, {31'b0, $signed(a) < $signed(b)});
    rd_mem(1, v);  chk("R5", "sw via sp wraps to word 1", v, a + b);
    rd_mem(3, v);  chk("R5", "sw word 3", v, a - b);
    rd_reg(8, v);  chk("R5", "lw after sw", v, a - b);
    rd_reg(9, v);  chk("R6", "beq", v, (a == b) ? 32'd0 : 32'd1);
    rd_reg(10, v); chk("R6", "bne", v, (a != b) ? 32'd0 : 32'd1);
    rd_reg(11, v); chk("R7", "blt", v, ($signed(a) < $signed(b)) ? 32'd0 : 32'd1);
    rd_reg(12, v); chk("R7", "bnez", v, (a != 0) ? 32'd0 : 32'd1);
    rd_reg(13, v); chk("R7", "bgez", v, ($signed(a) >= 0) ? 32'd0 : 32'd1);
    rd_reg(31, v); chk("R8", "jal link", v, 32'd92);
    rd_reg(15, v); chk("R8", "link seen by callee", v, 32'd92);
    rd_reg(14, v); chk("R9", "return lands after call", v, 32'd7);
    rd_reg(16, v); chk("R8", "jump skips", v, 32'd0);
    rd_reg(0, v);  chk("R2", "r0 write ignored", v, 32'd0);
    rd_reg(18, v); chk("R6", "backward loop counter", v, 32'd0);
    rd_reg(19, v); chk("R6", "backward loop trips", v, 32'd3);
    rd_reg(29, v); chk("R1", "sp untouched", v, 32'd128);

    // write while running must not land (R10)
    imem_write(33, enc_i(O_ADDI, 0, 20, 1));
    repeat (6) @(negedge clk_i);
    chk("R10", "pc stays in halt loop", pc_o, HALT_PC);
    rd_reg(20, v); chk("R10", "running write ignored", v, 32'd0);
  endtask

  initial begin
    logic [31:0] ops [8];
    ops[0] = 32'h0000_0000; ops[1] = 32'h0000_0001; ops[2] = 32'hFFFF_FFFF;
    ops[3] = 32'h7FFF_FFFF; ops[4] = 32'h8000_0000; ops[5] = 32'h0000_0005;
    ops[6] = 32'hFFFF_FFFB; ops[7] = 32'h1234_8765;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        run_pair(ops[i], ops[j]);
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule